// File: doc/BRIEF.md
# Virtual Interrupt Request and Service Tracker

This block keeps the virtual interrupt state of one virtual processor. It holds a request bitmap and an in-service bitmap, each with one bit per vector, plus three cached bytes. The first is the highest requesting vector. The second is the vector currently being serviced. The third is the processor priority. An emulated device raises an interrupt by posting a vector number. Once the class of the highest request outranks the current priority, the block flags it as pending.

A deliver strobe takes the pending vector into service. It raises the priority to that vector's class, clears the request bit and recomputes the highest request. An end-of-interrupt strobe retires the highest in-service vector. It notifies the downstream interrupt controller with that vector, lowers the priority to the class of the next vector still in service, and raises a re-evaluation pulse so that waiting requests are looked at again.

If both strobes arrive in the same cycle, the retirement is applied first and the delivery is judged against the lowered priority. All result outputs are registered. They change on the clock edge that samples the strobe.

Top module: `vint_tracker`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is 0: no pulse, no pending request, and requesting vector, servicing vector and priority all 0.
- R2: A post of vector v with v >= 16 sets request bit v. From the next edge, `req_vector` shows the highest set request bit, or 0 when none is set. Posting a vector that is already requested changes nothing.
- R3: Posts of vectors 0 to 15 leave the request bitmap unchanged, and `req_vector` is never a value from 1 to 15.
- R4: `pending_valid` is 1 exactly when bits [7:4] of `req_vector` are strictly greater than bits [7:4] of `prio`.
- R5: A deliver strobe while a request is pending produces, one cycle later, `deliver_valid`=1 with `deliver_vector` equal to the prior `req_vector`. At the same time `svc_vector` takes that vector, `prio` becomes the vector AND F0h, the vector's request bit is cleared, and `req_vector` becomes the next highest request or 0.
- R6: A deliver strobe while nothing is pending gives no `deliver_valid` pulse and leaves request vector, servicing vector and priority unchanged.
- R7: An end-of-interrupt strobe with at least one in-service bit set clears the highest one. One cycle later it pulses `eoi_notify` with `eoi_vector` equal to that vector, and pulses `reeval`.
- R8: After a retirement, `svc_vector` is the highest vector still in service (0 if none), and `prio` is that vector AND F0h.
- R9: An end-of-interrupt strobe with no in-service bit set pulses `eoi_none` only: no `eoi_notify`, no `reeval`, and no change to the servicing vector or the priority.
- R10: When deliver and end-of-interrupt strobes coincide, the retirement is applied first, and deliverability is compared against the priority left after that retirement.
- R11: A post of the same vector that is being delivered in that cycle leaves its request bit set, so it remains the requesting vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Post strobe |
| post_vector | input | 8 | Vector to request |
| deliver | input | 1 | Deliver strobe |
| deliver_valid | output | 1 | Pulse: a vector was taken into service |
| deliver_vector | output | 8 | Vector taken into service |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_notify | output | 1 | Pulse: notification to the downstream controller |
| eoi_vector | output | 8 | Retired vector |
| eoi_none | output | 1 | Pulse: end-of-interrupt found nothing in service |
| reeval | output | 1 | Pulse: re-evaluate pending requests |
| pending_valid | output | 1 | Highest request outranks current priority |
| req_vector | output | 8 | Highest requesting vector, 0 if none |
| svc_vector | output | 8 | Servicing vector |
| prio | output | 8 | Processor priority, class in bits [7:4] |

## Verification
The bench uses the default build, with 8-bit vectors, a 4-bit priority class and a post floor of 16. This covers the full bitmap, including vector 255 at its top edge and the 15/16 boundary of the post filter. With classes of 16 vectors, the bench can build the equal-class case where a request waits behind service of the same class, the stacked case where retirement falls back to a lower in-service vector, and the coincident end-of-interrupt with delivery whose outcome depends on the order in which the two are applied.

// File: rtl/vint_pkg.sv
package vint_pkg;
    parameter int VEC_W        = 8;
    parameter int CLASS_W      = 4;
    parameter int NUM_VEC      = 1 << VEC_W;
    parameter int MIN_POST_DEF = 1 << CLASS_W;

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [NUM_VEC-1:0] bmap_t;
    typedef logic [CLASS_W-1:0] class_t;

    typedef enum logic [1:0] {
        EOI_IDLE   = 2'd0,
        EOI_RETIRE = 2'd1,
        EOI_EMPTY  = 2'd2
    } eoi_res_e;

    function automatic class_t vec_class(input vec_t v);
        return v[VEC_W-1 -: CLASS_W];
    endfunction

    function automatic vec_t class_floor(input vec_t v);
        vec_t r;
        r = '0;
        r[VEC_W-1 -: CLASS_W] = v[VEC_W-1 -: CLASS_W];
        return r;
    endfunction
endpackage

// File: rtl/vint_hi_enc.sv
module vint_hi_enc #(
    parameter int N = 256,
    parameter int W = 8
) (
    input  logic [N-1:0] bits,
    output logic         found,
    output logic [W-1:0] index
);
    always_comb begin
        found = 1'b0;
        index = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                index = W'(i);
            end
        end
    end
endmodule

// File: rtl/vint_vec_dec.sv
module vint_vec_dec #(
    parameter int N   = 256,
    parameter int W   = 8,
    parameter int MIN = 0
) (
    input  logic         en,
    input  logic [W-1:0] vec,
    output logic [N-1:0] onehot
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        if (g < MIN) begin : g_blocked
            assign onehot[g] = 1'b0;
        end else begin : g_open
            assign onehot[g] = en && (vec == W'(g));
        end
    end
endmodule

// File: rtl/vint_tracker.sv
module vint_tracker
    import vint_pkg::*;
#(
    parameter int MIN_POST = MIN_POST_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             post_valid,
    input  logic [VEC_W-1:0] post_vector,
    input  logic             deliver,
    output logic             deliver_valid,
    output logic [VEC_W-1:0] deliver_vector,
    input  logic             eoi,
    output logic             eoi_notify,
    output logic [VEC_W-1:0] eoi_vector,
    output logic             eoi_none,
    output logic             reeval,
    output logic             pending_valid,
    output logic [VEC_W-1:0] req_vector,
    output logic [VEC_W-1:0] svc_vector,
    output logic [VEC_W-1:0] prio
);
    bmap_t irr_q, isr_q;
    vec_t  rvi_q, svi_q, ppr_q;

    // retirement stage: highest in-service vector
    logic  isr_hit;
    vec_t  isr_top;
    logic  eoi_hit;
    bmap_t eoi_clr, isr_a;
    logic  rem_hit;
    vec_t  rem_top, rem_vec, svi_a, ppr_a;

    vint_hi_enc #(.N(NUM_VEC), .W(VEC_W)) u_isr_enc (
        .bits(isr_q), .found(isr_hit), .index(isr_top));

    assign eoi_hit = eoi && isr_hit;

    vint_vec_dec #(.N(NUM_VEC), .W(VEC_W), .MIN(0)) u_eoi_dec (
        .en(eoi_hit), .vec(isr_top), .onehot(eoi_clr));

    assign isr_a = isr_q & ~eoi_clr;

    vint_hi_enc #(.N(NUM_VEC), .W(VEC_W)) u_rem_enc (
        .bits(isr_a), .found(rem_hit), .index(rem_top));

    assign rem_vec = rem_hit ? rem_top : '0;
    assign svi_a   = eoi_hit ? rem_vec : svi_q;
    assign ppr_a   = eoi_hit ? class_floor(rem_vec) : ppr_q;

    // delivery stage, judged against post-retirement priority
    logic  take;
    bmap_t dlv_oh, post_oh, irr_n, isr_n;
    logic  req_hit;
    vec_t  req_top;

    assign take = deliver && (vec_class(rvi_q) > vec_class(ppr_a));

    vint_vec_dec #(.N(NUM_VEC), .W(VEC_W), .MIN(0)) u_dlv_dec (
        .en(take), .vec(rvi_q), .onehot(dlv_oh));

    vint_vec_dec #(.N(NUM_VEC), .W(VEC_W), .MIN(MIN_POST)) u_post_dec (
        .en(post_valid), .vec(post_vector), .onehot(post_oh));

    assign isr_n = isr_a | dlv_oh;
    assign irr_n = (irr_q & ~dlv_oh) | post_oh;

    vint_hi_enc #(.N(NUM_VEC), .W(VEC_W)) u_req_enc (
        .bits(irr_n), .found(req_hit), .index(req_top));

    eoi_res_e eoi_res;
    always_comb begin
        if (eoi_hit)  eoi_res = EOI_RETIRE;
        else if (eoi) eoi_res = EOI_EMPTY;
        else          eoi_res = EOI_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q          <= '0;
            isr_q          <= '0;
            rvi_q          <= '0;
            svi_q          <= '0;
            ppr_q          <= '0;
            deliver_valid  <= 1'b0;
            deliver_vector <= '0;
            eoi_notify     <= 1'b0;
            eoi_vector     <= '0;
            eoi_none       <= 1'b0;
            reeval         <= 1'b0;
        end else begin
            irr_q         <= irr_n;
            isr_q         <= isr_n;
            rvi_q         <= req_hit ? req_top : '0;
            svi_q         <= take ? rvi_q : svi_a;
            ppr_q         <= take ? class_floor(rvi_q) : ppr_a;
            deliver_valid <= take;
            if (take) deliver_vector <= rvi_q;
            eoi_notify    <= (eoi_res == EOI_RETIRE);
            reeval        <= (eoi_res == EOI_RETIRE);
            eoi_none      <= (eoi_res == EOI_EMPTY);
            if (eoi_res == EOI_RETIRE) eoi_vector <= isr_top;
        end
    end

    assign pending_valid = vec_class(rvi_q) > vec_class(ppr_q);
    assign req_vector    = rvi_q;
    assign svc_vector    = svi_q;
    assign prio          = ppr_q;
endmodule

// File: rtl/vint_tracker_chk.sv
module vint_tracker_chk
    import vint_pkg::*;
#(
    parameter int MIN_POST = MIN_POST_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             deliver,
    input logic             deliver_valid,
    input logic [VEC_W-1:0] deliver_vector,
    input logic             eoi,
    input logic             eoi_notify,
    input logic [VEC_W-1:0] eoi_vector,
    input logic             eoi_none,
    input logic             reeval,
    input logic             pending_valid,
    input logic [VEC_W-1:0] req_vector,
    input logic [VEC_W-1:0] svc_vector,
    input logic [VEC_W-1:0] prio
);
    a_r3_req_never_low: assert property (@(posedge clk) disable iff (rst)
        (req_vector == '0) || (int'(req_vector) >= MIN_POST));

    a_r4_pending_has_request: assert property (@(posedge clk) disable iff (rst)
        pending_valid |-> (req_vector != '0));

    a_r5_deliver_takes_req: assert property (@(posedge clk) disable iff (rst)
        deliver_valid |-> (deliver_vector == $past(req_vector)));

    a_r5_deliver_sets_state: assert property (@(posedge clk) disable iff (rst)
        deliver_valid |-> (svc_vector == deliver_vector) && (prio == class_floor(deliver_vector)));

    a_r6_deliver_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        deliver_valid |-> $past(deliver));

    a_r7_notify_with_reeval: assert property (@(posedge clk) disable iff (rst)
        eoi_notify |-> $past(eoi) && reeval);

    a_r8_fall_back_lower: assert property (@(posedge clk) disable iff (rst)
        (eoi_notify && !deliver_valid) |->
            (svc_vector < eoi_vector) && (prio == class_floor(svc_vector)));

    a_r9_eoi_outcome_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(eoi_notify && eoi_none));
endmodule

bind vint_tracker vint_tracker_chk #(.MIN_POST(MIN_POST)) u_chk (
    .clk(clk), .rst(rst), .deliver(deliver), .deliver_valid(deliver_valid),
    .deliver_vector(deliver_vector), .eoi(eoi), .eoi_notify(eoi_notify),
    .eoi_vector(eoi_vector), .eoi_none(eoi_none), .reeval(reeval),
    .pending_valid(pending_valid), .req_vector(req_vector),
    .svc_vector(svc_vector), .prio(prio));

// File: tb/vint_tracker_test.sv
`timescale 1ns/1ps
module vint_tracker_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       post_valid = 1'b0;
    logic [7:0] post_vector = '0;
    logic       deliver = 1'b0;
    logic       eoi = 1'b0;
    logic       deliver_valid, eoi_notify, eoi_none, reeval, pending_valid;
    logic [7:0] deliver_vector, eoi_vector, req_vector, svc_vector, prio;

    always #2 clk = ~clk;

    vint_tracker uut (
        .clk(clk), .rst(rst), .post_valid(post_valid), .post_vector(post_vector),
        .deliver(deliver), .deliver_valid(deliver_valid), .deliver_vector(deliver_vector),
        .eoi(eoi), .eoi_notify(eoi_notify), .eoi_vector(eoi_vector), .eoi_none(eoi_none),
        .reeval(reeval), .pending_valid(pending_valid), .req_vector(req_vector),
        .svc_vector(svc_vector), .prio(prio));

    typedef struct {
        string      tag;
        logic       dv, en, enone, rv, pend;
        logic [7:0] dvec, evec, rvi, svi, ppr;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         fails  = 0;
    logic [255:0] m_irr = '0, m_isr = '0;
    logic [7:0] m_rvi = '0, m_svi = '0, m_ppr = '0;

    function automatic int top_bit(input logic [255:0] b);
        int r = -1;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input logic pv, input logic [7:0] pvec,
                        input logic dl, input logic e, input string tag);
        exp_t x;
        int   t;
        @(negedge clk);
        post_valid = pv; post_vector = pvec; deliver = dl; eoi = e;
        x.tag = tag; x.dv = 0; x.en = 0; x.enone = 0; x.rv = 0;
        x.dvec = 0; x.evec = 0;
        t = top_bit(m_isr);
        if (e && t >= 0) begin
            m_isr[t] = 1'b0;
            x.en = 1; x.rv = 1; x.evec = 8'(t);
            t = top_bit(m_isr);
            m_svi = (t >= 0) ? 8'(t) : 8'h00;
            m_ppr = m_svi & 8'hF0;
        end else if (e) begin
            x.enone = 1;
        end
        if (dl && (m_rvi[7:4] > m_ppr[7:4])) begin
            x.dv = 1; x.dvec = m_rvi;
            m_isr[m_rvi] = 1'b1;
            m_irr[m_rvi] = 1'b0;
            m_svi = m_rvi;
            m_ppr = m_rvi & 8'hF0;
        end
        if (pv && pvec >= 8'd16) m_irr[pvec] = 1'b1;
        t = top_bit(m_irr);
        m_rvi = (t >= 0) ? 8'(t) : 8'h00;
        x.rvi = m_rvi; x.svi = m_svi; x.ppr = m_ppr;
        x.pend = m_rvi[7:4] > m_ppr[7:4];
        sb.push_back(x);
    endtask

    // monitor: compare just after each edge
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            chk(x.tag, "deliver_valid", deliver_valid, x.dv);
            if (x.dv) chk(x.tag, "deliver_vector", deliver_vector, x.dvec);
            chk(x.tag, "eoi_notify", eoi_notify, x.en);
            if (x.en) chk(x.tag, "eoi_vector", eoi_vector, x.evec);
            chk(x.tag, "eoi_none", eoi_none, x.enone);
            chk(x.tag, "reeval", reeval, x.rv);
            chk(x.tag, "pending_valid", pending_valid, x.pend);
            chk(x.tag, "req_vector", req_vector, x.rvi);
            chk(x.tag, "svc_vector", svc_vector, x.svi);
            chk(x.tag, "prio", prio, x.ppr);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs during reset
        chk("R1", "reset outputs",
            int'({deliver_valid, eoi_notify, eoi_none, reeval, pending_valid}), 0);
        chk("R1", "reset vectors", int'(req_vector | svc_vector | prio), 0);
        @(negedge clk) rst = 1'b0;
        step(0, 8'h00, 0, 0, "R1");
        step(1, 8'h35, 0, 0, "R2");
        step(1, 8'h35, 0, 0, "R2");       // repost is idempotent
        step(1, 8'h0F, 0, 0, "R3");       // below floor: ignored
        step(1, 8'h10, 0, 0, "R3");       // at floor: accepted
        step(1, 8'h72, 0, 0, "R4");
        step(0, 8'h00, 1, 0, "R5");       // deliver 0x72
        step(0, 8'h00, 1, 0, "R6");       // 0x35 below class 7: ignored
        step(1, 8'h7A, 0, 0, "R4");       // same class: not pending
        step(1, 8'h80, 0, 0, "R4");       // higher class: pending
        step(0, 8'h00, 1, 0, "R5");       // deliver 0x80
        step(0, 8'h00, 0, 1, "R7");       // retire 0x80, fall back to 0x72
        step(0, 8'h00, 0, 0, "R8");
        step(0, 8'h00, 1, 1, "R10");      // retire 0x72 then deliver 0x7A
        step(0, 8'h00, 0, 1, "R8");       // retire 0x7A, nothing left
        step(1, 8'h35, 1, 0, "R11");      // deliver 0x35 while reposting it
        step(0, 8'h00, 0, 1, "R7");
        step(0, 8'h00, 0, 1, "R9");       // empty retirement
        step(0, 8'h00, 1, 0, "R5");       // deliver the reposted 0x35
        step(1, 8'hFF, 0, 0, "R2");
        step(0, 8'h00, 1, 0, "R5");       // deliver vector 255
        step(1, 8'h00, 1, 0, "R3");       // vector 0 post ignored, not pending
        step(0, 8'h00, 0, 1, "R8");       // retire 0xFF, fall back to 0x35
        step(0, 8'h00, 0, 1, "R7");
        step(0, 8'h00, 0, 1, "R9");
        step(0, 8'h00, 0, 0, "R6");
        repeat (3) @(posedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule